// File: doc/BRIEF.md
# Active-Low Network Interrupt Collector

This block gathers per-port interrupt requests coming from two network expansion slots and folds them into one interrupt line toward the CPU. Each slot owns a 16-bit status word. A bit in that word is 0 while the matching port has an interrupt pending and 1 when it is idle. Both words start out as all ones.

Each slot has a raise request and a drop request, and each request carries a port number. A raise marks the port pending. A drop returns the port to idle. A fixed per-slot map gives the status word each slot writes and the bit offset at which its ports begin.

The CPU line is high whenever any word holds a zero bit. Software reads either word through a simple read port. A read only observes the word: it clears nothing.

Top module: `netirq_collector`

## Requirements
- R1: After reset both status words read 0xFFFF and `irq_out` is low.
- R2: A raise for slot s and port p clears bit p of status word s (offset 0) at the next clock edge and leaves every other bit unchanged.
- R3: A drop for slot s and port p sets bit p of status word s back to 1 at the next clock edge and leaves every other bit unchanged.
- R4: `irq_out` is high when either status word differs from 0xFFFF and low only when both equal 0xFFFF. It changes one clock edge after the request that caused the change.
- R5: With `rd_en` high, `rd_addr` 0x26 returns status word 0 and `rd_addr` 0x28 returns status word 1, combinationally. Any other address, or `rd_en` low, returns 0x0000.
- R6: Reading a status word, once or many times, changes neither status word nor `irq_out`.
- R7: When a raise and a drop for the same bit arrive in the same cycle, the bit ends up pending (0).
- R8: A request whose port number is 16 or more changes no status bit.
- R9: Slot 0 requests affect only status word 0, and slot 1 requests affect only status word 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| raise_vld | input | 2 | Per-slot raise request strobe (bit s = slot s) |
| raise_port | input | 10 | Per-slot raise port number, slot s at bits [5s+4:5s] |
| drop_vld | input | 2 | Per-slot drop request strobe (bit s = slot s) |
| drop_port | input | 10 | Per-slot drop port number, slot s at bits [5s+4:5s] |
| rd_en | input | 1 | Read enable |
| rd_addr | input | 8 | Register address for reads |
| rd_data | output | 16 | Status word selected by the read, or 0 |
| irq_out | output | 1 | Aggregate interrupt to the CPU, active high |

## Verification
Single raises on each slot show that the correct word and bit go to 0 and that the other word stays clean. They also show that the line rises one edge after the request and not before. Raises on both slots followed by one drop show that the line compares both words, not just the last one touched. A raise and a drop on the same bit in one cycle confirm that the pending state wins. Port numbers of 16 and above, repeated reads, and reads of unmapped addresses confirm that none of these disturbs the stored state.

// File: rtl/netirq_pkg.sv
package netirq_pkg;
  localparam int DEF_WORD_W    = 16;
  localparam int DEF_NUM_SLOTS = 2;
  localparam int DEF_NUM_WORDS = 2;
  localparam int DEF_PORT_W    = 5;
  localparam int DEF_ADDR_W    = 8;
  localparam int REG_BASE      = 'h26;
  localparam int REG_STEP      = 2;

  // status word written by a slot
  function automatic int slot_word(input int slot);
    case (slot)
      0:       return 0;
      1:       return 1;
      default: return 0;
    endcase
  endfunction

  // bit position of a slot's port 0 inside its word
  function automatic int slot_offset(input int slot);
    case (slot)
      0:       return 0;
      1:       return 0;
      default: return 0;
    endcase
  endfunction

  // register address of a status word
  function automatic int word_addr(input int word);
    return REG_BASE + REG_STEP * word;
  endfunction
endpackage

// File: rtl/netirq_slot_decode.sv
module netirq_slot_decode #(
  parameter int WORD_W = 16,
  parameter int PORT_W = 5,
  parameter int OFFSET = 0
) (
  input  logic              raise_vld,
  input  logic [PORT_W-1:0] raise_port,
  input  logic              drop_vld,
  input  logic [PORT_W-1:0] drop_port,
  output logic [WORD_W-1:0] set_mask,
  output logic [WORD_W-1:0] clr_mask,
  output logic              raise_hit,
  output logic              drop_hit
);
  // one-hot bit for a port, or zero when it falls past the word
  function automatic logic [WORD_W-1:0] port_bit(input logic [PORT_W-1:0] port);
    int pos;
    pos = OFFSET + int'(port);
    if (pos < WORD_W) return WORD_W'(1) << pos;
    return '0;
  endfunction

  always_comb begin
    set_mask  = raise_vld ? port_bit(raise_port) : '0;
    clr_mask  = drop_vld  ? port_bit(drop_port)  : '0;
    raise_hit = |set_mask;
    drop_hit  = |clr_mask;
  end
endmodule

// File: rtl/netirq_status_word.sv
module netirq_status_word #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] set_mask,
  input  logic [WORD_W-1:0] clr_mask,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] word_nxt;

  // drop returns bits to 1 first, raise then forces them to 0 (raise wins)
  always_comb word_nxt = (word | clr_mask) & ~set_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word <= '1;
    else        word <= word_nxt;
  end

  AST_RAISE_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mask != '0) |=> ((word & $past(set_mask)) == '0)); // R2
  AST_DROP_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_mask & ~set_mask) != '0) |=>
      ((word & $past(clr_mask & ~set_mask)) == $past(clr_mask & ~set_mask))); // R3
  AST_COLLIDE_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_mask & clr_mask) != '0) |=> ((word & $past(set_mask & clr_mask)) == '0)); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mask == '0 && clr_mask == '0) |=> $stable(word)); // R9
endmodule

// File: rtl/netirq_readback.sv
module netirq_readback #(
  parameter int WORD_W    = 16,
  parameter int NUM_WORDS = 2,
  parameter int ADDR_W    = 8
) (
  input  logic [NUM_WORDS*WORD_W-1:0] words,
  input  logic                        rd_en,
  input  logic [ADDR_W-1:0]           rd_addr,
  output logic [WORD_W-1:0]           rd_data
);
  import netirq_pkg::*;

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      for (int w = 0; w < NUM_WORDS; w++) begin
        if (rd_addr == ADDR_W'(word_addr(w))) rd_data = words[w*WORD_W +: WORD_W];
      end
    end
  end
endmodule

// File: rtl/netirq_collector.sv
module netirq_collector #(
  parameter int WORD_W    = netirq_pkg::DEF_WORD_W,
  parameter int NUM_SLOTS = netirq_pkg::DEF_NUM_SLOTS,
  parameter int NUM_WORDS = netirq_pkg::DEF_NUM_WORDS,
  parameter int PORT_W    = netirq_pkg::DEF_PORT_W,
  parameter int ADDR_W    = netirq_pkg::DEF_ADDR_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_SLOTS-1:0]        raise_vld,
  input  logic [NUM_SLOTS*PORT_W-1:0] raise_port,
  input  logic [NUM_SLOTS-1:0]        drop_vld,
  input  logic [NUM_SLOTS*PORT_W-1:0] drop_port,
  input  logic                        rd_en,
  input  logic [ADDR_W-1:0]           rd_addr,
  output logic [WORD_W-1:0]           rd_data,
  output logic                        irq_out
);
  import netirq_pkg::*;

  localparam int ALL_W = NUM_WORDS * WORD_W;

  logic [NUM_SLOTS*WORD_W-1:0] slot_set, slot_clr;
  logic [NUM_SLOTS-1:0]        raise_hit, drop_hit;
  logic [ALL_W-1:0]            word_set, word_clr, all_words;
  logic [NUM_WORDS-1:0]        word_busy;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    netirq_slot_decode #(
      .WORD_W (WORD_W),
      .PORT_W (PORT_W),
      .OFFSET (slot_offset(s))
    ) u_dec (
      .raise_vld  (raise_vld[s]),
      .raise_port (raise_port[s*PORT_W +: PORT_W]),
      .drop_vld   (drop_vld[s]),
      .drop_port  (drop_port[s*PORT_W +: PORT_W]),
      .set_mask   (slot_set[s*WORD_W +: WORD_W]),
      .clr_mask   (slot_clr[s*WORD_W +: WORD_W]),
      .raise_hit  (raise_hit[s]),
      .drop_hit   (drop_hit[s])
    );
  end

  // route each slot's masks to the word the map assigns it
  always_comb begin
    word_set = '0;
    word_clr = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      for (int s = 0; s < NUM_SLOTS; s++) begin
        if (slot_word(s) == w) begin
          word_set[w*WORD_W +: WORD_W] |= slot_set[s*WORD_W +: WORD_W];
          word_clr[w*WORD_W +: WORD_W] |= slot_clr[s*WORD_W +: WORD_W];
        end
      end
    end
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    netirq_status_word #(.WORD_W(WORD_W)) u_word (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_mask (word_set[w*WORD_W +: WORD_W]),
      .clr_mask (word_clr[w*WORD_W +: WORD_W]),
      .word     (all_words[w*WORD_W +: WORD_W])
    );
    assign word_busy[w] = (all_words[w*WORD_W +: WORD_W] != {WORD_W{1'b1}});
  end

  assign irq_out = |word_busy;

  netirq_readback #(
    .WORD_W    (WORD_W),
    .NUM_WORDS (NUM_WORDS),
    .ADDR_W    (ADDR_W)
  ) u_rd (
    .words   (all_words),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  AST_RAISE_LIFTS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (|raise_hit) |=> irq_out); // R4
  AST_IRQ_FALL_NEEDS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_out) |-> $past(|drop_hit)); // R4
  AST_READ_NO_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && raise_vld == '0 && drop_vld == '0) |=> ($stable(all_words) && $stable(irq_out))); // R6
  AST_WIDE_PORT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (raise_vld != '0 && raise_hit == '0 && drop_vld == '0) |=> $stable(all_words)); // R8
endmodule

// File: tb/netirq_collector_tb.sv
`timescale 1ns/100ps
module netirq_collector_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  raise_vld = '0, drop_vld = '0;
  logic [9:0]  raise_port = '0, drop_port = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        irq_out;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [15:0] exp_w [2];

  always #2.5 clk = ~clk;

  netirq_collector dut_i (
    .clk(clk), .rst_n(rst_n), .raise_vld(raise_vld), .raise_port(raise_port),
    .drop_vld(drop_vld), .drop_port(drop_port), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq_out(irq_out));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    rd_en = 1'b1; rd_addr = a; #0.2;
    d = rd_data;
    rd_en = 1'b0; #0.1;
  endtask

  function automatic logic exp_irq();
    return (exp_w[0] != 16'hFFFF) || (exp_w[1] != 16'hFFFF);
  endfunction

  task automatic chk_state(input string tag);
    logic [15:0] d;
    rd(8'h26, d); chk({tag, " word0 R5"}, d, exp_w[0]);
    rd(8'h28, d); chk({tag, " word1 R5"}, d, exp_w[1]);
    chk({tag, " irq R4"}, {15'b0, irq_out}, {15'b0, exp_irq()});
  endtask

  // one request cycle; model: drop to 1, then raise to 0 (R7), ports >=16 dropped (R8)
  task automatic req(input logic [1:0] rv, input logic [4:0] rp0, input logic [4:0] rp1,
                     input logic [1:0] dv, input logic [4:0] dp0, input logic [4:0] dp1);
    logic [4:0] rp [2];
    logic [4:0] dp [2];
    @(negedge clk);
    raise_vld = rv; raise_port = {rp1, rp0};
    drop_vld  = dv; drop_port  = {dp1, dp0};
    #0.5;
    chk("irq before edge R4", {15'b0, irq_out}, {15'b0, exp_irq()});
    rp[0] = rp0; rp[1] = rp1; dp[0] = dp0; dp[1] = dp1;
    for (int s = 0; s < 2; s++) if (dv[s] && dp[s] < 16) exp_w[s][dp[s]] = 1'b1;
    for (int s = 0; s < 2; s++) if (rv[s] && rp[s] < 16) exp_w[s][rp[s]] = 1'b0;
    @(posedge clk); #0.5;
    raise_vld = '0; drop_vld = '0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk_state("reset R1");
    chk("reset irq R1", {15'b0, irq_out}, 16'h0);
    rd(8'h30, d); chk("unmapped addr R5", d, 16'h0000);
    rd_addr = 8'h26; #0.2; chk("rd_en low R5", rd_data, 16'h0000);
  endtask

  task automatic t_single();
    logic [15:0] d;
    req(2'b01, 5'd3, 5'd0, 2'b00, 5'd0, 5'd0);
    rd(8'h26, d); chk("slot0 port3 raise R2", d, 16'hFFF7);
    rd(8'h28, d); chk("slot0 leaves word1 R9", d, 16'hFFFF);
    chk("irq after raise R4", {15'b0, irq_out}, 16'h1);
    req(2'b00, 5'd0, 5'd0, 2'b01, 5'd3, 5'd0);
    rd(8'h26, d); chk("slot0 port3 drop R3", d, 16'hFFFF);
    chk("irq after drop R4", {15'b0, irq_out}, 16'h0);
  endtask

  task automatic t_both();
    logic [15:0] d;
    req(2'b11, 5'd0, 5'd15, 2'b00, 5'd0, 5'd0);
    rd(8'h28, d); chk("slot1 port15 raise R2 R9", d, 16'h7FFF);
    chk_state("both raised");
    req(2'b00, 5'd0, 5'd0, 2'b01, 5'd0, 5'd0);
    chk("irq held by word1 R4", {15'b0, irq_out}, 16'h1);
    chk_state("one dropped");
    req(2'b00, 5'd0, 5'd0, 2'b10, 5'd0, 5'd15);
    chk("irq low both clean R4", {15'b0, irq_out}, 16'h0);
    chk_state("both dropped");
  endtask

  task automatic t_reads();
    logic [15:0] d;
    req(2'b10, 5'd0, 5'd7, 2'b00, 5'd0, 5'd0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      rd(8'h28, d); chk("repeat read word1 R6", d, 16'hFF7F);
      rd(8'h26, d);
    end
    chk("irq survives reads R6", {15'b0, irq_out}, 16'h1);
    req(2'b00, 5'd0, 5'd0, 2'b10, 5'd0, 5'd7);
    chk_state("reads cleanup");
  endtask

  task automatic t_collide();
    logic [15:0] d;
    req(2'b01, 5'd5, 5'd0, 2'b01, 5'd5, 5'd0);
    rd(8'h26, d); chk("raise+drop same bit R7", d, 16'hFFDF);
    req(2'b00, 5'd0, 5'd0, 2'b01, 5'd9, 5'd0);
    rd(8'h26, d); chk("drop of idle bit R3", d, 16'hFFDF);
    req(2'b00, 5'd0, 5'd0, 2'b01, 5'd5, 5'd0);
    chk_state("collide cleanup");
  endtask

  task automatic t_wide();
    logic [15:0] d;
    req(2'b11, 5'd16, 5'd31, 2'b00, 5'd0, 5'd0);
    rd(8'h26, d); chk("port16 ignored R8", d, 16'hFFFF);
    rd(8'h28, d); chk("port31 ignored R8", d, 16'hFFFF);
    chk("irq quiet wide port R8", {15'b0, irq_out}, 16'h0);
    req(2'b10, 5'd0, 5'd2, 2'b00, 5'd0, 5'd0);
    req(2'b00, 5'd0, 5'd0, 2'b10, 5'd0, 5'd18);
    rd(8'h28, d); chk("wide drop ignored R8", d, 16'hFFFB);
    req(2'b00, 5'd0, 5'd0, 2'b10, 5'd0, 5'd2);
    chk_state("wide cleanup");
  endtask

  initial begin
    exp_w[0] = 16'hFFFF; exp_w[1] = 16'hFFFF;
    #12 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_both();
    t_reads();
    t_collide();
    t_wide();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule